// File: doc/BRIEF.md
# Configurable Pipeline Latch Flow Controller

This block holds one instruction register of an in-order pipeline and picks, every cycle, exactly one of three next-state actions for it. Normal flow loads an instruction word from one of several upstream (parent) latches. Stall keeps the current word. Nop insertion loads a bubble. The choice is made from the stall bits of the parent latches, the stall bits of the downstream (child) latches, and an external self-stall request. The block's own stall bit goes back to its parents.

Each of the five terms that feed the decision is built from a parent or child stall vector through a selector, fixed at synthesis time. The selector codes are 0 = NONE (the term has no effect), 1 = ANY, 2 = SOME (every bit in a chosen mask), 3 = ALL. The child term of the stall condition checks for stalled children. The parent and child terms of normal flow check for children and parents that are not stalled. Nop insertion checks for stalled parents and for children that are not stalled.

The register can also model a unit that takes several cycles. After it takes in a real instruction, an internal busy counter acts as a self-stall for MC_CYCLES-1 further cycles.

Top module: `pipe_latch_ctrl`

## Requirements
- R1: A synchronous reset loads NOP_WORD, drives valid_o low and clears the busy counter. The first cycle after reset is not busy.
- R2: With the default selectors, normal flow happens when at least one parent and at least one child are not stalled and there is no self-stall. ir_o then takes the chosen parent's word on the next clock edge.
- R3: In normal flow, the word comes from the lowest-index parent whose stall bit is 0. Parent k occupies bits [k*IW +: IW] of par_ir_i.
- R4: The latch stalls when the child stall term holds or when self_stall_i is 1. By default the child stall term is "all children stalled". While stalled, stall_o is 1 and ir_o and valid_o stay unchanged. Stall wins over flow and over nop insertion.
- R5: With the default selectors, nop insertion happens when all parents are stalled, at least one child is not stalled and there is no self-stall. ir_o becomes NOP_WORD and valid_o becomes 0.
- R6: valid_o is 0 exactly when ir_o equals NOP_WORD. This includes a NOP_WORD that arrives from a parent by normal flow.
- R7: Loading a word other than NOP_WORD makes the latch self-stalled for the next MC_CYCLES-1 cycles, whatever the other inputs are. Loading NOP_WORD starts no busy period.
- R8: The selectors use the codes 0 = NONE, 1 = ANY, 2 = SOME (all bits set in the mask), 3 = ALL. For example, with the child stall term set to SOME and mask 2'b10, only child 1 being stalled stalls the latch. With the normal-flow parent term set to ALL, one stalled parent blocks normal flow.
- R9: Exactly one action is taken per cycle. The order of priority is stall, then normal flow, then nop insertion, and a cycle with no true condition holds. stall_o is 1 exactly in holding cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| par_stall_i | input | NPAR | Stall bits of the parent latches |
| par_ir_i | input | NPAR*IW | Instruction words of the parents, parent k at [k*IW +: IW] |
| chd_stall_i | input | NCHD | Stall bits of the child latches |
| self_stall_i | input | 1 | External self-stall request |
| ir_o | output | IW | Latched instruction word |
| valid_o | output | 1 | 1 when ir_o is not NOP_WORD |
| stall_o | output | 1 | This latch holds in the current cycle |

## Verification
The bench drives the default configuration and a second configuration together. The second one uses the SOME and ALL selectors and has no busy period. Several cases are targeted, each against the wrong behaviour it would catch:
- A wrong parent priority would load parent 1 when parent 0 is free.
- A busy counter that is too short or too long would change ir_o during the busy cycles or hold past them.
- A busy period started by a flowed NOP_WORD would hold back the word that follows.
- A stall that loses to nop insertion would wipe a held instruction.
- A reset that leaves the counter set would block the first load after reset.

// File: rtl/pipe_latch_ctrl.sv
module pipe_latch_ctrl #(
  parameter int NPAR = 2,
  parameter int NCHD = 2,
  parameter int IW = 16,
  parameter logic [IW-1:0] NOP_WORD = '0,
  parameter int MC_CYCLES = 3,
  parameter logic [1:0] ST_CHD_SEL = 2'd3,
  parameter logic [1:0] NF_PAR_SEL = 2'd1,
  parameter logic [1:0] NF_CHD_SEL = 2'd1,
  parameter logic [1:0] NI_PAR_SEL = 2'd3,
  parameter logic [1:0] NI_CHD_SEL = 2'd1,
  parameter logic [NPAR-1:0] PAR_MASK = '1,
  parameter logic [NCHD-1:0] CHD_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPAR-1:0]    par_stall_i,
  input  logic [NPAR*IW-1:0] par_ir_i,
  input  logic [NCHD-1:0]    chd_stall_i,
  input  logic               self_stall_i,
  output logic [IW-1:0]      ir_o,
  output logic               valid_o,
  output logic               stall_o
);
  localparam int CW = $clog2(MC_CYCLES + 1);
  localparam logic [CW-1:0] BUSY_INIT = CW'(MC_CYCLES - 1);

  function automatic logic pick(input logic [1:0] sel, input logic any_t,
                                input logic some_t, input logic all_t,
                                input logic none_t);
    case (sel)
      2'd0:    return none_t;
      2'd1:    return any_t;
      2'd2:    return some_t;
      default: return all_t;
    endcase
  endfunction

  logic [IW-1:0] ir_q, sel_word;
  logic          vld_q;
  logic [CW-1:0] cnt_q;

  // stalled / free reductions over the parent and child vectors
  wire p_st_any  = |par_stall_i;
  wire p_st_all  = &par_stall_i;
  wire p_st_some = &(par_stall_i | ~PAR_MASK);
  wire p_ok_any  = ~&par_stall_i;
  wire p_ok_all  = ~|par_stall_i;
  wire p_ok_some = ~|(par_stall_i & PAR_MASK);
  wire c_st_any  = |chd_stall_i;
  wire c_st_all  = &chd_stall_i;
  wire c_st_some = &(chd_stall_i | ~CHD_MASK);
  wire c_ok_any  = ~&chd_stall_i;
  wire c_ok_all  = ~|chd_stall_i;
  wire c_ok_some = ~|(chd_stall_i & CHD_MASK);

  wire busy    = cnt_q != '0;
  wire self_st = self_stall_i | busy;

  wire st_c = pick(ST_CHD_SEL, c_st_any, c_st_some, c_st_all, 1'b0) | self_st;
  wire nf_c = pick(NF_PAR_SEL, p_ok_any, p_ok_some, p_ok_all, 1'b1)
            & pick(NF_CHD_SEL, c_ok_any, c_ok_some, c_ok_all, 1'b1) & ~self_st;
  wire ni_c = pick(NI_PAR_SEL, p_st_any, p_st_some, p_st_all, 1'b1)
            & pick(NI_CHD_SEL, c_ok_any, c_ok_some, c_ok_all, 1'b1) & ~self_st;

  wire take_nf = ~st_c & nf_c;
  wire take_ni = ~st_c & ~nf_c & ni_c;
  wire hold    = ~take_nf & ~take_ni;

  always_comb begin
    sel_word = par_ir_i[0 +: IW];
    for (int k = NPAR - 1; k >= 0; k--)
      if (!par_stall_i[k]) sel_word = par_ir_i[k*IW +: IW];
  end

  wire load_real = take_nf & (sel_word != NOP_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= NOP_WORD;
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (take_nf) begin
        ir_q  <= sel_word;
        vld_q <= sel_word != NOP_WORD;
      end else if (take_ni) begin
        ir_q  <= NOP_WORD;
        vld_q <= 1'b0;
      end
      if (load_real) cnt_q <= BUSY_INIT;
      else if (busy) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ir_o    = ir_q;
  assign valid_o = vld_q;
  assign stall_o = hold;

  a_r1_reset: assert property (@(posedge clk)
    rst |=> (ir_o == NOP_WORD && !valid_o && !busy));
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> ($stable(ir_o) && $stable(valid_o)));
  a_r5_bubble: assert property (@(posedge clk) disable iff (rst)
    take_ni |=> (ir_o == NOP_WORD && !valid_o));
  a_r6_valid: assert property (@(posedge clk) disable iff (rst)
    valid_o == (ir_o != NOP_WORD));
  a_r9_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot({take_nf, take_ni, hold}));
  generate
    if (MC_CYCLES > 1) begin : g_mc
      a_r7_busy: assert property (@(posedge clk) disable iff (rst)
        load_real |=> stall_o);
    end
  endgenerate
endmodule

// File: tb/test_pipe_latch_ctrl.sv
module test_pipe_latch_ctrl;
  logic clk = 1'b0, rst = 1'b1, self_st = 1'b0;
  logic [1:0] ps = 2'b00, cs = 2'b00;
  logic [31:0] pir = '0;
  logic [15:0] ir_d, ir_a;
  logic v_d, v_a, st_d, st_a;
  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  pipe_latch_ctrl i_pipe_latch_ctrl (
    .clk(clk), .rst(rst), .par_stall_i(ps), .par_ir_i(pir), .chd_stall_i(cs),
    .self_stall_i(self_st), .ir_o(ir_d), .valid_o(v_d), .stall_o(st_d));

  pipe_latch_ctrl #(.MC_CYCLES(1), .ST_CHD_SEL(2'd2), .CHD_MASK(2'b10),
                    .NF_PAR_SEL(2'd3), .NI_PAR_SEL(2'd1)) i_alt (
    .clk(clk), .rst(rst), .par_stall_i(ps), .par_ir_i(pir), .chd_stall_i(cs),
    .self_stall_i(self_st), .ir_o(ir_a), .valid_o(v_a), .stall_o(st_a));

  typedef struct {
    logic [15:0] ir; logic v; logic [15:0] air; logic av; logic [63:0] tag;
  } item_t;
  item_t q[$];

  task automatic chk(input logic [63:0] tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %0s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] p, input logic [15:0] w0,
                      input logic [15:0] w1, input logic [1:0] c,
                      input logic s, input logic r,
                      input logic [15:0] eir, input logic ev, input logic est,
                      input logic [15:0] air, input logic av, input logic ast,
                      input logic [63:0] tag);
    item_t it;
    @(negedge clk);
    ps = p; pir = {w1, w0}; cs = c; self_st = s; rst = r;
    #1;
    chk({tag, "_R9"}, {15'd0, st_d}, {15'd0, est});
    chk({tag, "_R9a"}, {15'd0, st_a}, {15'd0, ast});
    it.ir = eir; it.v = ev; it.air = air; it.av = av; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, ir_d, it.ir);
      chk(it.tag, {15'd0, v_d}, {15'd0, it.v});
      chk({it.tag, "a"}, ir_a, it.air);
      chk({it.tag, "a"}, {15'd0, v_a}, {15'd0, it.av});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 2000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=2000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", ir_d, 16'h0000);
    chk("R1", {15'd0, v_d}, 16'd0);
    // args: ps w0 w1 cs self rst | exp ir v stall | alt ir v stall
    step(2'b00, 16'h1111, 16'h2222, 2'b00, 0, 0, 16'h1111, 1, 0, 16'h1111, 1, 0, "R2");
    step(2'b00, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h1111, 1, 1, 16'h3333, 1, 0, "R7");
    step(2'b00, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h1111, 1, 1, 16'h3333, 1, 0, "R7");
    step(2'b01, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h2222, 1, 0, 16'h0000, 0, 0, "R3");
    step(2'b11, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h2222, 1, 1, 16'h0000, 0, 0, "R7");
    step(2'b11, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h2222, 1, 1, 16'h0000, 0, 0, "R7");
    step(2'b11, 16'h3333, 16'h2222, 2'b00, 0, 0, 16'h0000, 0, 0, 16'h0000, 0, 0, "R5");
    step(2'b00, 16'h4444, 16'h2222, 2'b11, 0, 0, 16'h0000, 0, 1, 16'h0000, 0, 1, "R4");
    step(2'b00, 16'h4444, 16'h2222, 2'b01, 0, 0, 16'h4444, 1, 0, 16'h4444, 1, 0, "R8");
    step(2'b00, 16'h4444, 16'h2222, 2'b10, 0, 0, 16'h4444, 1, 1, 16'h4444, 1, 1, "R8");
    step(2'b00, 16'h4444, 16'h2222, 2'b00, 0, 0, 16'h4444, 1, 1, 16'h4444, 1, 0, "R7");
    step(2'b00, 16'h4444, 16'h2222, 2'b00, 1, 0, 16'h4444, 1, 1, 16'h4444, 1, 1, "R4");
    step(2'b10, 16'h5555, 16'h2222, 2'b00, 0, 0, 16'h5555, 1, 0, 16'h0000, 0, 0, "R3");
    step(2'b10, 16'h5555, 16'h2222, 2'b00, 0, 0, 16'h5555, 1, 1, 16'h0000, 0, 0, "R7");
    step(2'b10, 16'h5555, 16'h2222, 2'b00, 0, 0, 16'h5555, 1, 1, 16'h0000, 0, 0, "R7");
    step(2'b11, 16'h5555, 16'h2222, 2'b11, 0, 0, 16'h5555, 1, 1, 16'h0000, 0, 1, "R4");
    step(2'b00, 16'h0000, 16'h2222, 2'b00, 0, 0, 16'h0000, 0, 0, 16'h0000, 0, 0, "R6");
    step(2'b00, 16'h6666, 16'h2222, 2'b00, 0, 0, 16'h6666, 1, 0, 16'h6666, 1, 0, "R7");
    step(2'b00, 16'h7777, 16'h2222, 2'b00, 0, 1, 16'h0000, 0, 1, 16'h0000, 0, 0, "R1");
    step(2'b00, 16'h7777, 16'h2222, 2'b00, 0, 0, 16'h7777, 1, 0, 16'h7777, 1, 0, "R1");
    repeat (3) @(posedge clk);
    #2;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule